// File: doc/BRIEF.md
# NAND Flash Command and Data Front End

This block turns simple host register writes into NAND flash bus cycles. The host loads a packed control word that selects the page size, the bus width and separate read and write strobe lengths. After that, each write to the command, address or write-data register goes into a short in-order queue. A sequencer drains the queue one entry at a time and drives the entry onto the flash bus. Command entries assert CLE, address entries assert ALE, and data entries assert neither. Each entry gets one write-enable strobe.

Reads are split into two steps. A write of any value to the read-request register adds a read entry to the same queue. When the sequencer reaches that entry, it pulses read-enable, captures the flash data into a read-data register and raises a sticky read-ready status bit. Two more sticky status bits record the device leaving busy and the end of a page burst. A mask register gates these three bits onto a single interrupt line. All three bits are cleared by writing 1s.

A page-control register starts a whole-page burst, either read or write, as long as the block is idle. A burst moves one page of bytes, or one page of 16-bit words, through the burst data ports and then ends with a one-cycle done pulse. A write to the reset register aborts a burst that is under way.

Top module: `nand_fe`

## Requirements
- R1: After reset, both strobes are high, CLE and ALE are low, the status, interrupt-status and mask registers read 0, and `irq` is low.
- R2: A command-register write produces exactly one write strobe with CLE high and ALE low, carrying the written value on `nf_dout`; a write-data-register write produces one write strobe with CLE and ALE both low.
- R3: An address-register write produces exactly one write strobe with ALE high and CLE low.
- R4: A write strobe is held low for (control[3:0]+1) clocks and a read strobe for (control[7:4]+1) clocks.
- R5: Queued entries reach the flash bus in the order written. The queue holds 4 entries. Status bit 0 reads 1 while it is full, and a command, address, data or read-request write made while it is full is discarded.
- R6: A write of any value to the read-request register causes one read strobe. The sampled `nf_din` is held in the read-data register, and interrupt-status bit 1 is set and stays set until 1 is written to it.
- R7: With control bit 8 at 0 (8-bit bus), `nf_dout[15:8]` is driven 0 and read data is the zero-extended low byte of `nf_din`. With bit 8 at 1, all 16 bits pass through.
- R8: Status bit 1 follows the ready line. A low-to-high ready transition sets interrupt-status bit 0, which is cleared by writing 1 to it.
- R9: `irq` is the OR of interrupt-status bits ANDed with the mask register, so it stays low while the mask is 0.
- R10: Writing 1 to page control starts a read burst and writing 2 starts a write burst. A burst moves 256 bytes (control bit 9 = 0) or 512 bytes (bit 9 = 1), which is half as many strobes on a 16-bit bus. It then gives exactly one `burst_done` pulse and sets interrupt-status bit 2.
- R11: A page-control value other than 1 or 2, or any page-control write made while the block is busy or its queue is not empty, starts no burst. A reset-register write stops a running burst at once, with no `burst_done`, and status bit 2 (busy) then reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobe lengths are counted in its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 4 | Register select: 0 control, 1 status, 2 int-status, 3 mask, 4 command, 5 address, 6 write data, 7 read request, 8 read data, 9 page control, 10 reset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Contents of the selected register |
| irq | output | 1 | Masked interrupt |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dout | output | 16 | Data driven to the flash |
| nf_dout_en | output | 1 | Output enable for `nf_dout` |
| nf_din | input | 16 | Data from the flash |
| nf_rb | input | 1 | Flash ready (1) / busy (0) |
| burst_wdata | input | 16 | Word to send in a write burst |
| burst_rdata | output | 16 | Last word captured |
| burst_beat | output | 1 | One pulse per burst word transferred |
| burst_done | output | 1 | One-cycle end-of-burst pulse |

## Verification
The bench uses the default parameters: a four-entry queue, four-bit strobe delays and a 256-byte small page. With these values, an eight-cycle write strobe keeps the sequencer busy long enough for back-to-back host writes to fill the queue and show that the sixth write is dropped. Strobe delays of 3 and 5 separate the read and write lengths. The default page size keeps every burst length short enough to count completely: 128 words for a small page on a 16-bit bus and 512 strobes for a large page on an 8-bit bus. The abort case is hit in the middle of a large burst.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;

    localparam int unsigned BUS_W  = 16;
    localparam int unsigned ADDR_W = 4;

    // host register map
    localparam logic [ADDR_W-1:0] RA_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] RA_STAT  = 4'd1;
    localparam logic [ADDR_W-1:0] RA_ISTAT = 4'd2;
    localparam logic [ADDR_W-1:0] RA_IMASK = 4'd3;
    localparam logic [ADDR_W-1:0] RA_CMD   = 4'd4;
    localparam logic [ADDR_W-1:0] RA_ADDR  = 4'd5;
    localparam logic [ADDR_W-1:0] RA_WDAT  = 4'd6;
    localparam logic [ADDR_W-1:0] RA_RDREQ = 4'd7;
    localparam logic [ADDR_W-1:0] RA_RDAT  = 4'd8;
    localparam logic [ADDR_W-1:0] RA_PAGE  = 4'd9;
    localparam logic [ADDR_W-1:0] RA_RST   = 4'd10;

    typedef enum logic [1:0] {
        OP_CMD  = 2'd0,
        OP_ADDR = 2'd1,
        OP_DATA = 2'd2,
        OP_READ = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_LOW  = 2'd1,
        SQ_HIGH = 2'd2
    } sq_e;

    typedef struct packed {
        op_e              op;
        logic [BUS_W-1:0] data;
    } entry_t;

endpackage

// File: rtl/nand_fe_wbuf.sv
module nand_fe_wbuf
    import nand_fe_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  entry_t                       push_ent,
    input  logic                         pop,
    output entry_t                       head,
    output logic                         full,
    output logic                         empty,
    output logic [$clog2(DEPTH+1)-1:0]   count
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        entry_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]   rptr;
        logic [PTR_W-1:0]   wptr;
        logic [CNT_W-1:0]   cnt;
    } wb_t;

    wb_t q, d;
    logic push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d       = q;
        push_ok = push && (q.cnt != CNT_W'(DEPTH));
        pop_ok  = pop && (q.cnt != '0);
        if (push_ok) begin
            d.mem[q.wptr] = push_ent;
            d.wptr        = nxt(q.wptr);
        end
        if (pop_ok) begin
            d.rptr = nxt(q.rptr);
        end
        d.cnt = q.cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head  = q.mem[q.rptr];
    assign full  = (q.cnt == CNT_W'(DEPTH));
    assign empty = (q.cnt == '0);
    assign count = q.cnt;

endmodule

// File: rtl/nand_fe_seq.sv
module nand_fe_seq
    import nand_fe_pkg::*;
#(
    parameter int unsigned DLY_W      = 4,
    parameter int unsigned SMALL_PAGE = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wide,
    input  logic             page_large,
    input  logic [DLY_W-1:0] wr_dly,
    input  logic [DLY_W-1:0] rd_dly,
    input  logic             q_valid,
    input  entry_t           q_head,
    output logic             q_pop,
    input  logic             burst_req,
    input  logic             burst_rd,
    input  logic             abort,
    input  logic [BUS_W-1:0] burst_wdata,
    input  logic [BUS_W-1:0] nf_din,
    output logic             we_n,
    output logic             re_n,
    output logic             cle,
    output logic             ale,
    output logic [BUS_W-1:0] dout,
    output logic             dout_en,
    output logic [BUS_W-1:0] rdata,
    output logic             rd_done,
    output logic             beat,
    output logic             done,
    output logic             busy
);

    localparam int unsigned PG_W   = $clog2(2 * SMALL_PAGE + 1);
    localparam int unsigned HALF_W = BUS_W / 2;

    typedef struct packed {
        sq_e              st;
        op_e              op;
        logic [BUS_W-1:0] data;
        logic [DLY_W-1:0] cnt;
        logic             in_burst;
        logic [PG_W-1:0]  left;
        logic [BUS_W-1:0] rdata;
        logic             rd_done;
        logic             beat;
        logic             done;
    } sq_t;

    sq_t q, d;
    logic [PG_W-1:0] page_bytes, page_words;

    always_comb begin
        page_bytes = page_large ? PG_W'(2 * SMALL_PAGE) : PG_W'(SMALL_PAGE);
        page_words = wide ? (page_bytes >> 1) : page_bytes;
    end

    always_comb begin
        d         = q;
        d.rd_done = 1'b0;
        d.beat    = 1'b0;
        d.done    = 1'b0;
        q_pop     = 1'b0;
        unique case (q.st)
            SQ_IDLE: begin
                if (burst_req) begin
                    d.in_burst = 1'b1;
                    d.left     = page_words;
                    d.op       = burst_rd ? OP_READ : OP_DATA;
                    d.cnt      = burst_rd ? rd_dly : wr_dly;
                    d.data     = burst_wdata;
                    d.st       = SQ_LOW;
                end else if (q_valid) begin
                    q_pop      = 1'b1;
                    d.in_burst = 1'b0;
                    d.op       = q_head.op;
                    d.data     = q_head.data;
                    d.cnt      = (q_head.op == OP_READ) ? rd_dly : wr_dly;
                    d.st       = SQ_LOW;
                end
            end
            SQ_LOW: begin
                if (q.cnt == '0) begin
                    d.st = SQ_HIGH;
                    if (q.op == OP_READ) begin
                        d.rdata   = wide ? nf_din : {{HALF_W{1'b0}}, nf_din[HALF_W-1:0]};
                        d.rd_done = !q.in_burst;
                    end
                    d.beat = q.in_burst;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            SQ_HIGH: begin
                if (q.in_burst && (q.left != PG_W'(1))) begin
                    d.left = q.left - 1'b1;
                    d.cnt  = (q.op == OP_READ) ? rd_dly : wr_dly;
                    d.data = burst_wdata;
                    d.st   = SQ_LOW;
                end else begin
                    d.done     = q.in_burst;
                    d.in_burst = 1'b0;
                    d.st       = SQ_IDLE;
                end
            end
            default: d.st = SQ_IDLE;
        endcase
        if (abort) begin
            d.st       = SQ_IDLE;
            d.in_burst = 1'b0;
            d.rd_done  = 1'b0;
            d.beat     = 1'b0;
            d.done     = 1'b0;
            q_pop      = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy    = (q.st != SQ_IDLE);
    assign we_n    = !((q.st == SQ_LOW) && (q.op != OP_READ));
    assign re_n    = !((q.st == SQ_LOW) && (q.op == OP_READ));
    assign cle     = busy && (q.op == OP_CMD);
    assign ale     = busy && (q.op == OP_ADDR);
    assign dout_en = busy && (q.op != OP_READ);
    assign dout    = wide ? q.data : {{HALF_W{1'b0}}, q.data[HALF_W-1:0]};
    assign rdata   = q.rdata;
    assign rd_done = q.rd_done;
    assign beat    = q.beat;
    assign done    = q.done;

endmodule

// File: rtl/nand_fe.sv
module nand_fe
    import nand_fe_pkg::*;
#(
    parameter int unsigned DEPTH      = 4,
    parameter int unsigned DLY_W      = 4,
    parameter int unsigned SMALL_PAGE = 256
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_wr,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic [BUS_W-1:0]     host_wdata,
    output logic [BUS_W-1:0]     host_rdata,
    output logic                 irq,
    output logic                 nf_cle,
    output logic                 nf_ale,
    output logic                 nf_we_n,
    output logic                 nf_re_n,
    output logic [BUS_W-1:0]     nf_dout,
    output logic                 nf_dout_en,
    input  logic [BUS_W-1:0]     nf_din,
    input  logic                 nf_rb,
    input  logic [BUS_W-1:0]     burst_wdata,
    output logic [BUS_W-1:0]     burst_rdata,
    output logic                 burst_beat,
    output logic                 burst_done
);

    localparam int unsigned RD_LSB   = DLY_W;
    localparam int unsigned WIDE_BIT = 2 * DLY_W;
    localparam int unsigned PAGE_BIT = 2 * DLY_W + 1;
    localparam int unsigned CTRL_W   = 2 * DLY_W + 2;
    localparam int unsigned IRQ_N    = 3;
    localparam int unsigned CNT_W    = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [IRQ_N-1:0]  istat;
        logic [IRQ_N-1:0]  imask;
        logic              rb_s1;
        logic              rb_s2;
        logic              rb_prev;
    } regs_t;

    regs_t q, d;

    logic             wide, page_large;
    logic [DLY_W-1:0] wr_dly, rd_dly;
    logic             push, pop, full, empty, busy;
    entry_t           push_ent, head;
    logic [CNT_W-1:0] wb_count;
    logic             burst_req, abort, rd_done;
    logic [BUS_W-1:0] rdata;
    logic [IRQ_N-1:0] irq_stat;

    assign wr_dly     = q.ctrl[DLY_W-1:0];
    assign rd_dly     = q.ctrl[RD_LSB +: DLY_W];
    assign wide       = q.ctrl[WIDE_BIT];
    assign page_large = q.ctrl[PAGE_BIT];
    assign irq_stat   = q.istat;

    // host write decode
    always_comb begin
        push        = 1'b0;
        push_ent.op = OP_CMD;
        push_ent.data = host_wdata;
        burst_req   = 1'b0;
        abort       = 1'b0;
        if (host_wr) begin
            unique case (host_addr)
                RA_CMD:   begin push = 1'b1; push_ent.op = OP_CMD;  end
                RA_ADDR:  begin push = 1'b1; push_ent.op = OP_ADDR; end
                RA_WDAT:  begin push = 1'b1; push_ent.op = OP_DATA; end
                RA_RDREQ: begin push = 1'b1; push_ent.op = OP_READ; end
                RA_PAGE:  burst_req = ((host_wdata == 16'd1) || (host_wdata == 16'd2))
                                      && !busy && empty;
                RA_RST:   abort = 1'b1;
                default:  ;
            endcase
        end
    end

    always_comb begin
        d         = q;
        d.rb_s1   = nf_rb;
        d.rb_s2   = q.rb_s1;
        d.rb_prev = q.rb_s2;
        if (host_wr && host_addr == RA_CTRL)  d.ctrl  = host_wdata[CTRL_W-1:0];
        if (host_wr && host_addr == RA_IMASK) d.imask = host_wdata[IRQ_N-1:0];
        if (host_wr && host_addr == RA_ISTAT) d.istat = q.istat & ~host_wdata[IRQ_N-1:0];
        if (q.rb_s2 && !q.rb_prev) d.istat[0] = 1'b1;
        if (rd_done)               d.istat[1] = 1'b1;
        if (burst_done)            d.istat[2] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // host read mux
    always_comb begin
        unique case (host_addr)
            RA_CTRL:  host_rdata = BUS_W'(q.ctrl);
            RA_STAT:  host_rdata = BUS_W'({busy, q.rb_s2, full});
            RA_ISTAT: host_rdata = BUS_W'(q.istat);
            RA_IMASK: host_rdata = BUS_W'(q.imask);
            RA_RDAT:  host_rdata = rdata;
            default:  host_rdata = '0;
        endcase
    end

    assign irq         = |(q.istat & q.imask);
    assign burst_rdata = rdata;

    nand_fe_wbuf #(.DEPTH(DEPTH)) wbuf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_ent (push_ent),
        .pop      (pop),
        .head     (head),
        .full     (full),
        .empty    (empty),
        .count    (wb_count)
    );

    nand_fe_seq #(.DLY_W(DLY_W), .SMALL_PAGE(SMALL_PAGE)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wide        (wide),
        .page_large  (page_large),
        .wr_dly      (wr_dly),
        .rd_dly      (rd_dly),
        .q_valid     (!empty),
        .q_head      (head),
        .q_pop       (pop),
        .burst_req   (burst_req),
        .burst_rd    (host_wdata == 16'd1),
        .abort       (abort),
        .burst_wdata (burst_wdata),
        .nf_din      (nf_din),
        .we_n        (nf_we_n),
        .re_n        (nf_re_n),
        .cle         (nf_cle),
        .ale         (nf_ale),
        .dout        (nf_dout),
        .dout_en     (nf_dout_en),
        .rdata       (rdata),
        .rd_done     (rd_done),
        .beat        (burst_beat),
        .done        (burst_done),
        .busy        (busy)
    );

endmodule

// File: rtl/nand_fe_chk.sv
module nand_fe_chk #(
    parameter int unsigned DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       nf_cle,
    input logic                       nf_ale,
    input logic                       nf_we_n,
    input logic                       nf_re_n,
    input logic [15:0]                nf_dout,
    input logic                       nf_dout_en,
    input logic                       wide,
    input logic                       burst_done,
    input logic                       rd_done,
    input logic [2:0]                 irq_stat,
    input logic [$clog2(DEPTH+1)-1:0] wb_count
);

    assert_cle_ale_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(nf_cle && nf_ale));

    assert_dout_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !nf_we_n |=> (nf_we_n || $stable(nf_dout)));

    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nf_we_n && !nf_re_n));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_count <= ($clog2(DEPTH+1))'(DEPTH));

    assert_rdready_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> irq_stat[1]);

    assert_narrow_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (nf_dout_en && !wide) |-> (nf_dout[15:8] == 8'h00));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |=> !burst_done);

    assert_done_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |=> irq_stat[2]);

endmodule

bind nand_fe nand_fe_chk #(.DEPTH(DEPTH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .nf_cle     (nf_cle),
    .nf_ale     (nf_ale),
    .nf_we_n    (nf_we_n),
    .nf_re_n    (nf_re_n),
    .nf_dout    (nf_dout),
    .nf_dout_en (nf_dout_en),
    .wide       (wide),
    .burst_done (burst_done),
    .rd_done    (rd_done),
    .irq_stat   (irq_stat),
    .wb_count   (wb_count)
);

// File: tb/nand_fe_tb_top.sv
`timescale 1ns/1ps
module nand_fe_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [3:0]  host_addr = 4'd0;
    logic [15:0] host_wdata = 16'd0;
    logic [15:0] host_rdata;
    logic        irq;
    logic        nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dout_en;
    logic [15:0] nf_dout;
    logic [15:0] nf_din = 16'd0;
    logic        nf_rb = 1'b0;
    logic [15:0] burst_wdata = 16'h5A5A;
    logic [15:0] burst_rdata;
    logic        burst_beat, burst_done;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    nand_fe dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
        .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
        .nf_dout(nf_dout), .nf_dout_en(nf_dout_en), .nf_din(nf_din), .nf_rb(nf_rb),
        .burst_wdata(burst_wdata), .burst_rdata(burst_rdata),
        .burst_beat(burst_beat), .burst_done(burst_done)
    );

    // ---------------- bus monitor (samples on falling edge) ----------------
    int          we_cnt = 0, re_cnt = 0, done_cnt = 0, beat_cnt = 0;
    int          we_len = 0, re_len = 0, we_last = 0, re_last = 0;
    logic        prev_we = 1'b1, prev_re = 1'b1;
    logic        log_cle [0:63];
    logic        log_ale [0:63];
    logic [15:0] log_dout [0:63];

    always @(negedge clk) begin
        if (rst_n) begin
            if (!nf_we_n) begin
                if (prev_we) begin
                    if (we_cnt < 64) begin
                        log_cle[we_cnt]  = nf_cle;
                        log_ale[we_cnt]  = nf_ale;
                        log_dout[we_cnt] = nf_dout;
                    end
                    we_cnt = we_cnt + 1;
                    we_len = 1;
                end else we_len = we_len + 1;
            end else if (!prev_we) we_last = we_len;
            if (!nf_re_n) begin
                if (prev_re) begin re_cnt = re_cnt + 1; re_len = 1; end
                else re_len = re_len + 1;
            end else if (!prev_re) re_last = re_len;
            if (burst_done) done_cnt = done_cnt + 1;
            if (burst_beat) beat_cnt = beat_cnt + 1;
            prev_we = nf_we_n;
            prev_re = nf_re_n;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] v);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = v;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk);
        host_addr = a;
        #0.5 v = host_rdata;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        logic [15:0] s;
        while (quiet < 3) begin
            rd(4'd1, s);
            quiet = s[2] ? 0 : quiet + 1;
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [15:0] v;
        check(nf_we_n && nf_re_n && !nf_cle && !nf_ale, "R1 bus idle", {nf_we_n, nf_re_n, nf_cle, nf_ale}, 4'b1100);
        rd(4'd1, v); check(v == 16'd0, "R1 status", v, 0);
        rd(4'd2, v); check(v == 16'd0, "R1 int-status", v, 0);
        rd(4'd3, v); check(v == 16'd0, "R1 mask", v, 0);
        check(!irq, "R1 irq", irq, 0);
    endtask

    task automatic t_cmd_addr_data();
        int b;
        wr(4'd0, 16'h0100 | 16'h0033);     // 16-bit, rd dly 3, wr dly 3
        b = we_cnt;
        wr(4'd4, 16'h00A5);
        wr(4'd5, 16'h1234);
        wr(4'd6, 16'hC3C3);
        wait_idle();
        check(we_cnt - b == 3, "R2 strobe count", we_cnt - b, 3);
        check(log_cle[b] && !log_ale[b], "R2 command CLE", {log_cle[b], log_ale[b]}, 2'b10);
        check(log_dout[b] == 16'h00A5, "R2 command value", log_dout[b], 16'h00A5);
        check(!log_cle[b+1] && log_ale[b+1], "R3 address ALE", {log_cle[b+1], log_ale[b+1]}, 2'b01);
        check(log_dout[b+1] == 16'h1234, "R3 address value", log_dout[b+1], 16'h1234);
        check(!log_cle[b+2] && !log_ale[b+2], "R2 data no latch", {log_cle[b+2], log_ale[b+2]}, 0);
        check(log_dout[b+2] == 16'hC3C3, "R7 16-bit data", log_dout[b+2], 16'hC3C3);
    endtask

    task automatic t_strobe_len();
        logic [15:0] v;
        wr(4'd0, 16'h0153);                 // rd dly 5, wr dly 3
        wr(4'd4, 16'h0070);
        wait_idle();
        check(we_last == 4, "R4 write strobe width", we_last, 4);
        nf_din = 16'h9A9A;
        wr(4'd7, 16'h0000);
        wait_idle();
        check(re_last == 6, "R4 read strobe width", re_last, 6);
        wr(4'd2, 16'h0002);
        rd(4'd2, v);
    endtask

    task automatic t_full();
        int b;
        logic [15:0] v;
        wr(4'd0, 16'h0107);                 // wr dly 7
        b = we_cnt;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            host_wr = 1'b1; host_addr = 4'd4; host_wdata = 16'(i);
        end
        @(negedge clk);
        host_wr = 1'b0;
        #0.5;
        host_addr = 4'd1;
        #0.5 v = host_rdata;
        check(v[0] == 1'b1, "R5 full flag", v[0], 1);
        wait_idle();
        check(we_cnt - b == 5, "R5 sixth write dropped", we_cnt - b, 5);
        for (int i = 0; i < 5; i++)
            check(log_dout[b+i] == 16'(i+1), "R5 in-order issue", log_dout[b+i], i+1);
        rd(4'd1, v);
        check(v[0] == 1'b0, "R5 full clears", v[0], 0);
    endtask

    task automatic t_read();
        logic [15:0] v;
        int b;
        wr(4'd0, 16'h0111);
        nf_din = 16'hBEEF;
        b = re_cnt;
        wr(4'd7, 16'hABCD);
        wait_idle();
        check(re_cnt - b == 1, "R6 one read strobe", re_cnt - b, 1);
        rd(4'd8, v); check(v == 16'hBEEF, "R6 read data", v, 16'hBEEF);
        rd(4'd2, v); check(v[1], "R6 ready set", v[1], 1);
        repeat (5) @(negedge clk);
        rd(4'd2, v); check(v[1], "R6 ready sticky", v[1], 1);
        wr(4'd2, 16'h0002);
        rd(4'd2, v); check(!v[1], "R6 write-1 clear", v[1], 0);
    endtask

    task automatic t_narrow();
        logic [15:0] v;
        int b;
        wr(4'd0, 16'h0011);                 // 8-bit
        b = we_cnt;
        wr(4'd4, 16'h1234);
        nf_din = 16'hBEEF;
        wr(4'd7, 16'h0000);
        wait_idle();
        check(log_dout[b] == 16'h0034, "R7 8-bit drive", log_dout[b], 16'h0034);
        rd(4'd8, v); check(v == 16'h00EF, "R7 8-bit capture", v, 16'h00EF);
        wr(4'd2, 16'h0002);
    endtask

    task automatic t_ready_irq();
        logic [15:0] v;
        check(!irq, "R9 irq low before event", irq, 0);
        nf_rb = 1'b1;
        repeat (6) @(negedge clk);
        rd(4'd1, v); check(v[1], "R8 ready level", v[1], 1);
        rd(4'd2, v); check(v[0], "R8 ready rise sets", v[0], 1);
        check(!irq, "R9 masked irq low", irq, 0);
        wr(4'd3, 16'h0001);
        #0.5 check(irq, "R9 unmasked irq", irq, 1);
        wr(4'd2, 16'h0001);
        rd(4'd2, v); check(!v[0], "R8 clear no new rise", v[0], 0);
        check(!irq, "R9 irq after clear", irq, 0);
        wr(4'd3, 16'h0000);
    endtask

    task automatic t_bursts();
        logic [15:0] v;
        int b, d0, bt;
        wr(4'd0, 16'h0100);                 // small page, 16-bit, no delay
        b = we_cnt; d0 = done_cnt; bt = beat_cnt;
        wr(4'd9, 16'h0002);
        wait_idle();
        check(we_cnt - b == 128, "R10 write burst words", we_cnt - b, 128);
        check(beat_cnt - bt == 128, "R10 write burst beats", beat_cnt - bt, 128);
        check(done_cnt - d0 == 1, "R10 one done", done_cnt - d0, 1);
        rd(4'd2, v); check(v[2], "R10 done status", v[2], 1);
        wr(4'd2, 16'h0004);
        wr(4'd0, 16'h0200);                 // large page, 8-bit
        b = re_cnt; d0 = done_cnt;
        wr(4'd9, 16'h0001);
        wait_idle();
        check(re_cnt - b == 512, "R10 read burst bytes", re_cnt - b, 512);
        check(done_cnt - d0 == 1, "R10 read done", done_cnt - d0, 1);
    endtask

    task automatic t_ignore_abort();
        logic [15:0] v;
        int b, r, d0;
        b = we_cnt; r = re_cnt; d0 = done_cnt;
        wr(4'd9, 16'h0003);
        repeat (10) @(negedge clk);
        check(we_cnt == b && re_cnt == r, "R11 bad page code", we_cnt + re_cnt - b - r, 0);
        rd(4'd1, v); check(!v[2], "R11 stays idle", v[2], 0);
        wr(4'd9, 16'h0001);
        repeat (20) @(negedge clk);
        wr(4'd9, 16'h0002);                 // while busy: ignored
        wr(4'd10, 16'h0000);
        repeat (40) @(negedge clk);
        rd(4'd1, v); check(!v[2], "R11 abort idle", v[2], 0);
        check(done_cnt == d0, "R11 no done on abort", done_cnt - d0, 0);
        check(re_cnt - r < 30, "R11 strobes stopped", re_cnt - r, 0);
        check(we_cnt == b, "R11 busy page write ignored", we_cnt - b, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_cmd_addr_data();
        t_strobe_len();
        t_full();
        t_read();
        t_narrow();
        t_ready_irq();
        t_bursts();
        t_ignore_abort();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule